// File: doc/BRIEF.md
# Soft-Stepped Stereo Digital Volume

This block scales a stereo stream of 16-bit signed samples by a per-channel digital gain. Gain is programmed in half-decibel steps. Ahead of the gain stage, a selector picks each channel's source. The source can be silence, the channel's own input, the opposite input, or the mean of the two. A two-bit link setting lets one channel take the other channel's gain code.

The applied gain does not jump to a new programmed value. It walks toward it one half-dB step at a time. The step rate is one step per sample, one step per two samples, or the change is applied at once.

Muting walks the applied gain down to the floor of the range. Once the floor is reached, the output is forced to zero. Unmuting walks the gain back up from the floor.

Each channel is controlled by a small state machine with three states:
- SILENT: muted and at the floor.
- RAMP: applied gain differs from its goal.
- HOLD: applied gain equals its goal.

The transitions are:
- unmute: SILENT to RAMP, or SILENT to HOLD when the programmed gain is itself the floor.
- arrive: RAMP to HOLD.
- retarget: HOLD to RAMP.
- floor-reached: RAMP or HOLD to SILENT, while muted.

A state moves only on a sample strobe. The output pair is registered on the clock edge that samples the strobe. That output uses the applied gain held before the same edge updates it.

Top module: `stereo_vol_ramp`

## Requirements
- R1: After reset, `out_valid` is 0, both outputs are 0, and the applied gain of both channels is at the floor (index 0, -63.5 dB). The state is SILENT, so the first strobe after reset yields zero output on both channels.
- R2: The gain code is an 8-bit two's-complement count c of half-dB steps, and its applied index is i = c + 127. With q = i + 5, e = q / 12 and m = q % 12, the output is floor(x * round(16384 * 2^(m/12)) / 2^(25 - e)). Here x is the routed input.
- R3: Code 0x80 is treated as 0x81 (-63.5 dB), and codes 0x31 to 0x7F are treated as 0x30 (+24 dB). The applied index never exceeds 175.
- R4: The route field of each channel works as follows: 00 selects zero, 01 selects the channel's own input, 10 selects the other input, and 11 selects floor((L + R) / 2).
- R5: When `step_mode` is 00, the applied gain moves by one index toward its goal on every strobe. The reserved code 11 behaves the same way. The gain never moves by more than one index per strobe in these modes.
- R6: When `step_mode` is 01, the gain moves one index only on strobes where a shared phase bit is 1. That bit is 0 after reset and toggles on every strobe. The applied gain does not change between strobes.
- R7: When `step_mode` is 10, the applied gain takes its goal on the next strobe.
- R8: The goal is the floor while a channel's mute is 1. A strobe taken while SILENT outputs exactly 0. After unmute, the gain steps up from the floor.
- R9: `link_mode` 01 makes the left channel use `gain_r`, and 10 makes the right channel use `gain_l`. With 00 or 11, each channel uses its own code.
- R10: `at_target_l` and `at_target_r` are 1 exactly when the applied index equals the index of the channel's programmed code, after linking and clamping, with mute ignored.
- R11: `out_valid` is 1 in the cycle after each strobe and 0 otherwise. The outputs hold their values between strobes.
- R12: Results beyond the 16-bit range saturate to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe per stereo sample |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| route_l | input | 2 | Left source select |
| route_r | input | 2 | Right source select |
| step_mode | input | 2 | Ramp rate select |
| link_mode | input | 2 | Gain code linking |
| mute_l | input | 1 | Left mute |
| mute_r | input | 1 | Right mute |
| gain_l | input | 8 | Left programmed gain code |
| gain_r | input | 8 | Right programmed gain code |
| out_valid | output | 1 | Output pair updated last cycle |
| out_l | output | 16 | Left output sample, signed |
| out_r | output | 16 | Right output sample, signed |
| at_target_l | output | 1 | Left applied gain equals programmed gain |
| at_target_r | output | 1 | Right applied gain equals programmed gain |

## Verification
The bench builds the block with its default 16-bit sample width, so the whole 8-bit code space can be swept exhaustively. It sweeps every gain code on both channels in the immediate mode, including both reserved ranges and full-scale inputs that saturate. It also walks all 16 route pairs and the four link settings. The small index range then allows full ramps to be followed strobe by strobe in each step mode, including a full mute descent of 127 steps to silence and the climb back. The output, valid flag and arrival flags are compared against an arithmetic model after every strobe.

// File: rtl/svr_pkg.sv
package svr_pkg;

    localparam int CODE_W     = 8;
    localparam int IDX_W      = 8;
    localparam int MIN_CODE   = -127;
    localparam int MAX_CODE   = 48;
    localparam int IDX_MAX    = MAX_CODE - MIN_CODE;
    localparam int OCT_STEPS  = 12;
    localparam int IDX_PAD    = (OCT_STEPS - ((-MIN_CODE) % OCT_STEPS)) % OCT_STEPS;
    localparam int UNITY_OCT  = (-MIN_CODE + IDX_PAD) / OCT_STEPS;
    localparam int MANT_W     = 16;
    localparam int MANT_FRAC  = 15;
    localparam int SHIFT_BASE = MANT_FRAC + UNITY_OCT - 1;

    localparam logic [1:0] SM_EVERY = 2'b00;
    localparam logic [1:0] SM_TWO   = 2'b01;
    localparam logic [1:0] SM_JUMP  = 2'b10;

    localparam logic [1:0] RT_OFF   = 2'b00;
    localparam logic [1:0] RT_OWN   = 2'b01;
    localparam logic [1:0] RT_OTHER = 2'b10;

    localparam logic [1:0] LK_L_FROM_R = 2'b01;
    localparam logic [1:0] LK_R_FROM_L = 2'b10;

    typedef enum logic [1:0] {
        ST_SILENT = 2'b00,
        ST_RAMP   = 2'b01,
        ST_HOLD   = 2'b10
    } step_state_t;

    // Q1.15 mantissa for 2^(m/12) / 2
    function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] m);
        case (m)
            4'd0:    return 16'd16384;
            4'd1:    return 16'd17358;
            4'd2:    return 16'd18390;
            4'd3:    return 16'd19484;
            4'd4:    return 16'd20643;
            4'd5:    return 16'd21870;
            4'd6:    return 16'd23170;
            4'd7:    return 16'd24548;
            4'd8:    return 16'd26008;
            4'd9:    return 16'd27554;
            4'd10:   return 16'd29193;
            4'd11:   return 16'd30929;
            default: return 16'd16384;
        endcase
    endfunction

    // Clamp a reserved code to the legal range and return its index
    function automatic logic [IDX_W-1:0] code_to_idx(input logic [CODE_W-1:0] c);
        int v;
        v = int'($signed(c));
        if (v < MIN_CODE) v = MIN_CODE;
        if (v > MAX_CODE) v = MAX_CODE;
        return IDX_W'(v - MIN_CODE);
    endfunction

endpackage

// File: rtl/svr_route.sv
module svr_route
    import svr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]               sel,
    input  logic signed [DATA_W-1:0] own,
    input  logic signed [DATA_W-1:0] other,
    output logic signed [DATA_W-1:0] y
);
    logic signed [DATA_W:0] sum;

    always_comb begin
        sum = {own[DATA_W-1], own} + {other[DATA_W-1], other};
        case (sel)
            RT_OFF:   y = '0;
            RT_OWN:   y = own;
            RT_OTHER: y = other;
            default:  y = DATA_W'(sum >>> 1);
        endcase
    end
endmodule

// File: rtl/svr_gain.sv
module svr_gain
    import svr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic [IDX_W-1:0]         idx,
    output logic signed [DATA_W-1:0] y
);
    localparam int PROD_W = DATA_W + MANT_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    logic [IDX_W:0]             q;
    logic [3:0]                 oct;
    logic [3:0]                 frac;
    logic [4:0]                 sh;
    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   shifted;

    always_comb begin
        q       = {1'b0, idx} + (IDX_W + 1)'(IDX_PAD);
        oct     = 4'(q / (IDX_W + 1)'(OCT_STEPS));
        frac    = 4'(q % (IDX_W + 1)'(OCT_STEPS));
        sh      = 5'(SHIFT_BASE) - {1'b0, oct};
        prod    = $signed({{(MANT_W + 1){x[DATA_W-1]}}, x})
                * $signed({{(DATA_W + 1){1'b0}}, mant_of(frac)});
        shifted = prod >>> sh;
        if (shifted > SAT_HI)      y = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) y = SAT_LO[DATA_W-1:0];
        else                       y = DATA_W'(shifted);
    end
endmodule

// File: rtl/svr_step_fsm.sv
module svr_step_fsm
    import svr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             tick,
    input  logic             jump,
    input  logic             mute,
    input  logic [IDX_W-1:0] target,
    output logic [IDX_W-1:0] app,
    output logic             silent
);
    step_state_t      state, state_nx;
    logic [IDX_W-1:0] goal, app_nx;
    logic             floor_mute;

    always_comb begin
        goal = mute ? '0 : target;
        if (jump)             app_nx = goal;
        else if (!tick)       app_nx = app;
        else if (app < goal)  app_nx = app + IDX_W'(1);
        else if (app > goal)  app_nx = app - IDX_W'(1);
        else                  app_nx = app;

        floor_mute = mute && (app_nx == '0);
        unique case (state)
            ST_SILENT: begin
                if (mute)                state_nx = ST_SILENT;
                else if (app_nx == goal) state_nx = ST_HOLD;
                else                     state_nx = ST_RAMP;
            end
            ST_RAMP: begin
                if (floor_mute)          state_nx = ST_SILENT;
                else if (app_nx == goal) state_nx = ST_HOLD;
                else                     state_nx = ST_RAMP;
            end
            ST_HOLD: begin
                if (floor_mute)          state_nx = ST_SILENT;
                else if (app_nx != goal) state_nx = ST_RAMP;
                else                     state_nx = ST_HOLD;
            end
            default:                     state_nx = ST_SILENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SILENT;
            app   <= '0;
        end else if (strobe) begin
            state <= state_nx;
            app   <= app_nx;
        end
    end

    assign silent = (state == ST_SILENT);
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
    import svr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] in_l,
    input  logic signed [DATA_W-1:0] in_r,
    input  logic [1:0]               route_l,
    input  logic [1:0]               route_r,
    input  logic [1:0]               step_mode,
    input  logic [1:0]               link_mode,
    input  logic                     mute_l,
    input  logic                     mute_r,
    input  logic [CODE_W-1:0]        gain_l,
    input  logic [CODE_W-1:0]        gain_r,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r,
    output logic                     at_target_l,
    output logic                     at_target_r
);
    localparam int NCH = 2;

    logic signed [DATA_W-1:0] src    [NCH];
    logic signed [DATA_W-1:0] routed [NCH];
    logic signed [DATA_W-1:0] scaled [NCH];
    logic [1:0]               rsel   [NCH];
    logic [CODE_W-1:0]        code   [NCH];
    logic [IDX_W-1:0]         tgt    [NCH];
    logic [IDX_W-1:0]         app_idx[NCH];
    logic [NCH-1:0]           mute_v;
    logic [NCH-1:0]           silent;
    logic [NCH-1:0]           at_tgt;
    logic                     phase;
    logic                     tick;
    logic                     jump;

    assign src[0]  = in_l;
    assign src[1]  = in_r;
    assign rsel[0] = route_l;
    assign rsel[1] = route_r;
    assign mute_v  = {mute_r, mute_l};

    always_comb begin
        code[0] = gain_l;
        code[1] = gain_r;
        case (link_mode)
            LK_L_FROM_R: code[0] = gain_r;
            LK_R_FROM_L: code[1] = gain_l;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         phase <= 1'b0;
        else if (smp_valid) phase <= ~phase;
    end

    assign tick = smp_valid && ((step_mode != SM_TWO) || phase);
    assign jump = smp_valid && (step_mode == SM_JUMP);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        svr_route #(.DATA_W(DATA_W)) u_route (
            .sel   (rsel[c]),
            .own   (src[c]),
            .other (src[NCH-1-c]),
            .y     (routed[c])
        );

        assign tgt[c] = code_to_idx(code[c]);

        svr_step_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (smp_valid),
            .tick   (tick),
            .jump   (jump),
            .mute   (mute_v[c]),
            .target (tgt[c]),
            .app    (app_idx[c]),
            .silent (silent[c])
        );

        svr_gain #(.DATA_W(DATA_W)) u_gain (
            .x   (routed[c]),
            .idx (app_idx[c]),
            .y   (scaled[c])
        );

        assign at_tgt[c] = (app_idx[c] == tgt[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_l <= silent[0] ? '0 : scaled[0];
                out_r <= silent[1] ? '0 : scaled[1];
            end
        end
    end

    assign at_target_l = at_tgt[0];
    assign at_target_r = at_tgt[1];
endmodule

// File: rtl/svr_checker.sv
module svr_checker
    import svr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic [1:0]               step_mode,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_l,
    input logic signed [DATA_W-1:0] out_r,
    input logic [IDX_W-1:0]         app_l,
    input logic [IDX_W-1:0]         app_r,
    input logic                     silent_l,
    input logic                     silent_r
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid); // R11
    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid)); // R11
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(out_l) && $stable(out_r))); // R11
    AST_SINGLE_STEP_L: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && step_mode != SM_JUMP) |=>
        (app_l == $past(app_l) || app_l == $past(app_l) + IDX_W'(1) || app_l + IDX_W'(1) == $past(app_l))); // R5
    AST_SINGLE_STEP_R: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && step_mode != SM_JUMP) |=>
        (app_r == $past(app_r) || app_r == $past(app_r) + IDX_W'(1) || app_r + IDX_W'(1) == $past(app_r))); // R5
    AST_GAIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (app_l <= IDX_W'(IDX_MAX)) && (app_r <= IDX_W'(IDX_MAX))); // R3
    AST_APP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(app_l) && $stable(app_r))); // R6
    AST_SILENT_ZERO_L: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && silent_l) |=> (out_l == '0)); // R8
    AST_SILENT_ZERO_R: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && silent_r) |=> (out_r == '0)); // R8
endmodule

bind stereo_vol_ramp svr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .step_mode (step_mode),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r),
    .app_l     (app_idx[0]),
    .app_r     (app_idx[1]),
    .silent_l  (silent[0]),
    .silent_r  (silent[1])
);

// File: tb/stereo_vol_ramp_bench.sv
`timescale 1ns/1ps
module stereo_vol_ramp_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic [1:0]        route_l = 2'b01, route_r = 2'b01;
    logic [1:0]        step_mode = 2'b00, link_mode = 2'b00;
    logic              mute_l = 1'b1, mute_r = 1'b1;
    logic [7:0]        gain_l = 8'h00, gain_r = 8'h00;
    logic              out_valid;
    logic signed [15:0] out_l, out_r;
    logic              at_target_l, at_target_r;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_app [2];
    bit m_silent [2];
    bit m_phase;

    always #4 clk = ~clk;

    stereo_vol_ramp u_stereo_vol_ramp (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .in_l(in_l), .in_r(in_r), .route_l(route_l), .route_r(route_r),
        .step_mode(step_mode), .link_mode(link_mode),
        .mute_l(mute_l), .mute_r(mute_r), .gain_l(gain_l), .gain_r(gain_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
        .at_target_l(at_target_l), .at_target_r(at_target_r)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp_idx(logic [7:0] c);
        int v = int'($signed(c));
        if (v < -127) v = -127;
        if (v > 48) v = 48;
        return v + 127;
    endfunction

    function automatic int gain_of(int x, int idx);
        int q = idx + 5;
        int e = q / 12;
        int m = q % 12;
        int mant = $rtoi(16384.0 * $pow(2.0, real'(m) / 12.0) + 0.5);
        longint p = longint'(x) * longint'(mant);
        longint r = p >>> (25 - e);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int route_of(logic [1:0] sel, int own, int other);
        case (sel)
            2'b00: return 0;
            2'b01: return own;
            2'b10: return other;
            default: return (own + other) >>> 1;
        endcase
    endfunction

    function automatic int prog_idx(int c);
        logic [7:0] code;
        if (c == 0) code = (link_mode == 2'b01) ? gain_r : gain_l;
        else        code = (link_mode == 2'b10) ? gain_l : gain_r;
        return clamp_idx(code);
    endfunction

    // One strobe: predict, update model, check after the edge and one idle cycle later
    task automatic strobe(string tag);
        int e_out [2];
        int x, tgt, goal;
        bit mu;
        bit tck;
        for (int c = 0; c < 2; c++) begin
            x = route_of(c == 0 ? route_l : route_r,
                         c == 0 ? int'(in_l) : int'(in_r),
                         c == 0 ? int'(in_r) : int'(in_l));
            e_out[c] = m_silent[c] ? 0 : gain_of(x, m_app[c]);
        end
        tck = (step_mode != 2'b01) || m_phase;
        for (int c = 0; c < 2; c++) begin
            mu = (c == 0) ? mute_l : mute_r;
            tgt = prog_idx(c);
            goal = mu ? 0 : tgt;
            if (step_mode == 2'b10) m_app[c] = goal;
            else if (tck) begin
                if (m_app[c] < goal) m_app[c]++;
                else if (m_app[c] > goal) m_app[c]--;
            end
            m_silent[c] = mu && (m_app[c] == 0);
        end
        m_phase = ~m_phase;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R11", "out_valid after strobe", int'(out_valid), 1);
        chk(tag, "out_l", int'(out_l), e_out[0]);
        chk(tag, "out_r", int'(out_r), e_out[1]);
        chk("R10", "at_target_l", int'(at_target_l), int'(m_app[0] == prog_idx(0)));
        chk("R10", "at_target_r", int'(at_target_r), int'(m_app[1] == prog_idx(1)));
        @(negedge clk);
        chk("R11", "out_valid idle", int'(out_valid), 0);
        chk("R11", "out_l held", int'(out_l), e_out[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_app[0] = 0; m_app[1] = 0;
        m_silent[0] = 1; m_silent[1] = 1;
        m_phase = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_l", int'(out_l), 0);
        chk("R1", "out_r", int'(out_r), 0);
        chk("R1", "at_target_l", int'(at_target_l), 0);
        chk("R1", "at_target_r", int'(at_target_r), 0);
        in_l = 16'sd12345; in_r = -16'sd4321;
        strobe("R1");

        // R7 + R2: exhaustive code sweep with immediate stepping
        mute_l = 0; mute_r = 0; step_mode = 2'b10;
        for (int k = 0; k < 256; k++) begin
            gain_l = 8'(k); gain_r = 8'(255 - k);
            in_l = 16'((k * 997) % 65536 - 32768);
            in_r = 16'(32767 - (k * 613) % 65536);
            strobe("R7");
            in_l = 16'sd1000 + 16'(k); in_r = -16'sd7000;
            strobe("R2");
        end

        // R3 reserved code clamping
        gain_l = 8'h80; gain_r = 8'h31; in_l = 16'sd30000; in_r = 16'sd500;
        strobe("R3"); strobe("R3");
        gain_l = 8'h7F; gain_r = 8'h80; in_l = -16'sd300; in_r = -16'sd32000;
        strobe("R3"); strobe("R3");

        // R12 saturation at the top of the range
        gain_l = 8'h30; gain_r = 8'h30; in_l = 16'sd32767; in_r = -16'sd32768;
        strobe("R12"); strobe("R12");

        // R4 all route pairs at 0 dB
        gain_l = 8'h00; gain_r = 8'h00; in_l = 16'sd1001; in_r = -16'sd3002;
        strobe("R4");
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                route_l = 2'(a); route_r = 2'(b);
                strobe("R4");
                in_l = -in_l - 16'sd7;
            end
        route_l = 2'b01; route_r = 2'b01;

        // R9 link modes
        gain_l = 8'h10; gain_r = 8'hE0; in_l = 16'sd9000; in_r = 16'sd9000;
        for (int lk = 0; lk < 4; lk++) begin
            link_mode = 2'(lk);
            strobe("R9"); strobe("R9");
        end
        link_mode = 2'b00;
        gain_l = 8'h00; gain_r = 8'h00;
        strobe("R7");

        // R5 one step per strobe, then reserved mode walking back
        step_mode = 2'b00; gain_l = 8'h18; gain_r = 8'hF4;
        repeat (26) strobe("R5");
        step_mode = 2'b11; gain_l = 8'h00; gain_r = 8'h00;
        repeat (26) strobe("R5");

        // R6 one step per two strobes
        step_mode = 2'b01; gain_l = 8'hF0; gain_r = 8'h0A;
        repeat (44) strobe("R6");
        gain_l = 8'h00; gain_r = 8'h00;
        repeat (44) strobe("R6");

        // R8 mute descent to silence and climb back
        step_mode = 2'b00; in_l = 16'sd20000; in_r = 16'sd20000;
        mute_l = 1;
        repeat (132) strobe("R8");
        chk("R8", "left silent output", int'(out_l), 0);
        mute_l = 0;
        repeat (132) strobe("R8");
        chk("R8", "left restored at target", int'(at_target_l), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule